// File: doc/BRIEF.md
# Scheduled Multiply-Subtract-Add Unit

This unit evaluates `X = A*B - C*D + F` on signed 8-bit two's-complement operands. A build parameter, `SCHED`, chooses one of three hardware schedules, and each schedule trades cycle count against arithmetic resources.

- **One cycle:** two multipliers and the subtract/add chain work in a single long cycle.
- **Two cycles:** two multipliers register both products in the first cycle. The subtraction and the addition of F run in the second cycle.
- **Three cycles:** a single multiplier is shared. It forms A*B in the first cycle and C*D in the second, and the subtract and add run in the third.

A caller presents the operands with a one-cycle `start` strobe while `busy` is low. The operands are captured on that edge. `busy` then stays high for `SCHED` cycles. After that, `done` pulses for one cycle and the new result appears on `result`, which holds its value until the next completion.

The result is 18 bits signed, which is wide enough that no operand combination can overflow it.

Top module: `msa_unit`

## Requirements
- R1: `result` equals A*B - C*D + F, computed on signed two's-complement 8-bit operands, as an 18-bit signed value with no overflow. The extremes are 32767 (A=B=C=-128, D=127, F=127) and -32768 (A=-128, B=127, C=D=-128, F=-128).
- R2: Operands are sampled only on the edge where `start` is high and `busy` is low. Changing them afterwards has no effect on that computation's result.
- R3: A `start` that arrives while `busy` is high is ignored. The running computation completes with its own operands, and no extra completion follows.
- R4: After an accepted start, `busy` is high for exactly `SCHED` consecutive cycles, starting on the cycle after the capture edge.
- R5: `done` is high for one cycle, on the cycle in which `busy` has just fallen, which is `SCHED` edges after capture. `busy` is low in that cycle, and a `start` in that cycle is accepted.
- R6: `result` changes only in a cycle where `done` is high, and otherwise holds the last completed value.
- R7: All three schedules produce identical results for identical operands. The three-cycle schedule does so with a single shared multiplier.
- R8: While reset is high and right after it, `busy` and `done` are 0 and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a computation (honoured only when idle) |
| opA | input | 8 | Signed multiplicand of the first product |
| opB | input | 8 | Signed multiplier of the first product |
| opC | input | 8 | Signed multiplicand of the subtracted product |
| opD | input | 8 | Signed multiplier of the subtracted product |
| opF | input | 8 | Signed addend |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 18 | Signed result, held between completions |

## Verification
All three schedules run side by side on the same stimulus and are compared cycle by cycle against a behavioural latency model. Operand sets that drive each product to its most positive and most negative value separate a correct 18-bit sign extension from a truncated or zero-extended one. Random operands with random start spacing catch a swapped product or a wrong sign. Operands that are scrambled right after capture, and starts that land during busy, show whether the capture registers really hold. A start kept high across completions checks that a start is accepted in the done cycle.

// File: rtl/msa_pkg.sv
package msa_pkg;

  // Strobes from the sequencer to the datapath, one set per cycle.
  typedef struct packed {
    logic loadOps;    // capture all five operands
    logic capFirst;   // register the A*B product
    logic capSecond;  // register the C*D product
    logic mulSelCd;   // shared multiplier works on C,D instead of A,B
    logic capRes;     // register the final sum
  } msa_strobe_t;

endpackage

// File: rtl/msa_ctrl.sv
module msa_ctrl
  import msa_pkg::*;
#(
  parameter int SCHED = 3,
  localparam int STEP_W = $clog2(SCHED + 1)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  output msa_strobe_t strobes,
  output logic        busy,
  output logic        done
);

  logic              busyQ;
  logic              doneQ;
  logic [STEP_W-1:0] stepQ;
  logic              lastStep;

  assign lastStep = busyQ && (stepQ == STEP_W'(SCHED));

  always_comb begin
    strobes           = '0;
    strobes.loadOps   = start && !busyQ;
    strobes.capRes    = lastStep;
    strobes.capFirst  = (SCHED >= 2) && busyQ && (stepQ == STEP_W'(1));
    strobes.capSecond = busyQ && (((SCHED == 2) && (stepQ == STEP_W'(1))) ||
                                  ((SCHED == 3) && (stepQ == STEP_W'(2))));
    strobes.mulSelCd  = (SCHED == 3) && busyQ && (stepQ == STEP_W'(2));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busyQ <= 1'b0;
      stepQ <= '0;
      doneQ <= 1'b0;
    end else begin
      doneQ <= lastStep;
      if (strobes.loadOps) begin
        busyQ <= 1'b1;
        stepQ <= STEP_W'(1);
      end else if (busyQ) begin
        if (lastStep) begin
          busyQ <= 1'b0;
          stepQ <= '0;
        end else begin
          stepQ <= stepQ + STEP_W'(1);
        end
      end
    end
  end

  assign busy = busyQ;
  assign done = doneQ;

endmodule

// File: rtl/msa_datapath.sv
module msa_datapath
  import msa_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SCHED  = 3,
  localparam int PROD_W = 2 * DATA_W,
  localparam int RES_W  = PROD_W + 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  msa_strobe_t              strobes,
  input  logic signed [DATA_W-1:0] opA,
  input  logic signed [DATA_W-1:0] opB,
  input  logic signed [DATA_W-1:0] opC,
  input  logic signed [DATA_W-1:0] opD,
  input  logic signed [DATA_W-1:0] opF,
  output logic signed [RES_W-1:0]  result
);

  localparam int EXT_P = RES_W - PROD_W;
  localparam int EXT_F = RES_W - DATA_W;

  logic signed [DATA_W-1:0] aQ, bQ, cQ, dQ, fQ;
  logic signed [RES_W-1:0]  resQ;
  logic signed [PROD_W-1:0] firstProd;   // A*B feeding the final stage
  logic signed [PROD_W-1:0] secondProd;  // C*D feeding the final stage
  logic signed [RES_W-1:0]  finalSum;

  always_ff @(posedge clk) begin
    if (rst) begin
      aQ <= '0; bQ <= '0; cQ <= '0; dQ <= '0; fQ <= '0;
    end else if (strobes.loadOps) begin
      aQ <= opA; bQ <= opB; cQ <= opC; dQ <= opD; fQ <= opF;
    end
  end

  generate
    if (SCHED == 1) begin : g_oneCycle
      logic unusedStrobes;
      assign unusedStrobes = strobes.capFirst ^ strobes.capSecond ^ strobes.mulSelCd;
      assign firstProd  = aQ * bQ;
      assign secondProd = cQ * dQ;
    end else if (SCHED == 2) begin : g_twoCycle
      logic signed [PROD_W-1:0] abQ, cdQ;
      logic unusedStrobes;
      assign unusedStrobes = strobes.mulSelCd;
      always_ff @(posedge clk) begin
        if (rst) begin
          abQ <= '0;
          cdQ <= '0;
        end else begin
          if (strobes.capFirst)  abQ <= aQ * bQ;
          if (strobes.capSecond) cdQ <= cQ * dQ;
        end
      end
      assign firstProd  = abQ;
      assign secondProd = cdQ;
    end else begin : g_threeCycle
      logic signed [DATA_W-1:0] mulX, mulY;
      logic signed [PROD_W-1:0] sharedProd;
      logic signed [PROD_W-1:0] abQ, cdQ;
      assign mulX       = strobes.mulSelCd ? cQ : aQ;
      assign mulY       = strobes.mulSelCd ? dQ : bQ;
      assign sharedProd = mulX * mulY;
      always_ff @(posedge clk) begin
        if (rst) begin
          abQ <= '0;
          cdQ <= '0;
        end else begin
          if (strobes.capFirst)  abQ <= sharedProd;
          if (strobes.capSecond) cdQ <= sharedProd;
        end
      end
      assign firstProd  = abQ;
      assign secondProd = cdQ;
    end
  endgenerate

  // Subtract then add, both in the widened result format.
  always_comb begin
    logic signed [RES_W-1:0] extAb, extCd, extF;
    extAb    = {{EXT_P{firstProd[PROD_W-1]}}, firstProd};
    extCd    = {{EXT_P{secondProd[PROD_W-1]}}, secondProd};
    extF     = {{EXT_F{fQ[DATA_W-1]}}, fQ};
    finalSum = (extAb - extCd) + extF;
  end

  always_ff @(posedge clk) begin
    if (rst)                 resQ <= '0;
    else if (strobes.capRes) resQ <= finalSum;
  end

  assign result = resQ;

endmodule

// File: rtl/msa_unit.sv
module msa_unit
  import msa_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SCHED  = 3,
  localparam int RES_W = 2 * DATA_W + 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic signed [DATA_W-1:0] opA,
  input  logic signed [DATA_W-1:0] opB,
  input  logic signed [DATA_W-1:0] opC,
  input  logic signed [DATA_W-1:0] opD,
  input  logic signed [DATA_W-1:0] opF,
  output logic                     busy,
  output logic                     done,
  output logic signed [RES_W-1:0]  result
);

  msa_strobe_t strobes;

  msa_ctrl #(.SCHED(SCHED)) uCtrl (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .strobes (strobes),
    .busy    (busy),
    .done    (done)
  );

  msa_datapath #(.DATA_W(DATA_W), .SCHED(SCHED)) uPath (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .opA     (opA),
    .opB     (opB),
    .opC     (opC),
    .opD     (opD),
    .opF     (opF),
    .result  (result)
  );

endmodule

// File: rtl/msa_checker.sv
module msa_checker #(
  parameter int SCHED = 3,
  parameter int RES_W = 18
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [RES_W-1:0] result
);

  logic [7:0] busyRun;

  always_ff @(posedge clk) begin
    if (rst)       busyRun <= '0;
    else if (busy) busyRun <= busyRun + 8'd1;
    else           busyRun <= '0;
  end

  // R4: an idle start makes the unit busy on the next cycle
  assert_start_busy_R4: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  // R4: the busy window lasts exactly SCHED cycles
  assert_busy_len_R4: assert property (@(posedge clk) disable iff (rst)
    done |-> (busyRun == 8'(SCHED)));

  // R5: done comes only after a busy cycle and never overlaps busy
  assert_done_idle_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  // R3: while busy, the next cycle is either still busy or a completion
  assert_busy_ignores_R3: assert property (@(posedge clk) disable iff (rst)
    busy |=> (busy || done));

  // R6: result changes only with done
  assert_result_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(result));

endmodule

bind msa_unit msa_checker #(.SCHED(SCHED), .RES_W(RES_W)) uChecker (
  .clk    (clk),
  .rst    (rst),
  .start  (start),
  .busy   (busy),
  .done   (done),
  .result (result)
);

// File: tb/tb_msa_unit.sv
`timescale 1ns/1ps
module tb_msa_unit;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic signed [7:0] opA = '0, opB = '0, opC = '0, opD = '0, opF = '0;

  logic               busyV [3];
  logic               doneV [3];
  logic signed [17:0] resV  [3];

  int nChecks = 0;
  int nErrors = 0;

  always #5 clk = ~clk;

  // index k runs the schedule of length k+1
  msa_unit #(.SCHED(1)) dutOne (.clk(clk), .rst(rst), .start(start), .opA(opA), .opB(opB),
    .opC(opC), .opD(opD), .opF(opF), .busy(busyV[0]), .done(doneV[0]), .result(resV[0]));
  msa_unit #(.SCHED(2)) dutTwo (.clk(clk), .rst(rst), .start(start), .opA(opA), .opB(opB),
    .opC(opC), .opD(opD), .opF(opF), .busy(busyV[1]), .done(doneV[1]), .result(resV[1]));
  msa_unit #(.SCHED(3)) dut    (.clk(clk), .rst(rst), .start(start), .opA(opA), .opB(opB),
    .opC(opC), .opD(opD), .opF(opF), .busy(busyV[2]), .done(doneV[2]), .result(resV[2]));

  // Behavioural latency model per schedule
  bit mBusy [3];
  bit mDone [3];
  int mCnt  [3];
  int mRes  [3];
  int mPend [3];

  always @(posedge clk) begin
    for (int k = 0; k < 3; k++) begin
      if (rst) begin
        mBusy[k] = 0; mDone[k] = 0; mCnt[k] = 0; mRes[k] = 0; mPend[k] = 0;
      end else begin
        mDone[k] = 0;
        if (mBusy[k]) begin
          if (mCnt[k] == 1) begin
            mBusy[k] = 0; mDone[k] = 1; mRes[k] = mPend[k];
          end else begin
            mCnt[k] = mCnt[k] - 1;
          end
        end else if (start) begin
          mBusy[k] = 1;
          mCnt[k]  = k + 1;
          mPend[k] = int'(opA) * int'(opB) - int'(opC) * int'(opD) + int'(opF);
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int sched, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s sched=%0d actual=%0d expected=%0d", tag, sched, act, exp);
    end
  endtask

  // Every-cycle comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (!rst) begin
      for (int k = 0; k < 3; k++) begin
        check(busyV[k] == mBusy[k], "R4 busy", k + 1, int'(busyV[k]), int'(mBusy[k]));
        check(doneV[k] == mDone[k], "R5 done", k + 1, int'(doneV[k]), int'(mDone[k]));
        check(int'(resV[k]) == mRes[k], "R1/R6 result", k + 1, int'(resV[k]), mRes[k]);
      end
    end
  end

  task automatic pulseStart(input int a, input int b, input int c, input int d, input int f);
    opA = 8'(a); opB = 8'(b); opC = 8'(c); opD = 8'(d); opF = 8'(f);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    opA = 8'($urandom); opB = 8'($urandom); opC = 8'($urandom);
    opD = 8'($urandom); opF = 8'($urandom);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic checkAll(input string tag, input int exp);
    for (int k = 0; k < 3; k++)
      check(int'(resV[k]) == exp, tag, k + 1, int'(resV[k]), exp);
  endtask

  initial begin
    #(200000 * 10);
    nErrors++;
    $display("FAIL watchdog: run did not finish");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    idle(3);
    for (int k = 0; k < 3; k++) begin
      check(busyV[k] == 1'b0, "R8 busy in reset", k + 1, int'(busyV[k]), 0);
      check(doneV[k] == 1'b0, "R8 done in reset", k + 1, int'(doneV[k]), 0);
      check(resV[k] == '0, "R8 result in reset", k + 1, int'(resV[k]), 0);
    end
    rst = 1'b0;
    idle(2);

    // R1 positive extreme
    pulseStart(-128, -128, -128, 127, 127);
    idle(5);
    checkAll("R1 max", 32767);

    // R1 negative extreme
    pulseStart(-128, 127, -128, -128, -128);
    idle(5);
    checkAll("R1 min", -32768);

    // R6 hold after completion
    pulseStart(0, 0, 0, 0, -1);
    idle(5);
    checkAll("R6 hold a", -1);
    idle(7);
    checkAll("R6 hold b", -1);

    // R2 operands scrambled right after capture (pulseStart does this)
    pulseStart(5, 6, 7, 8, 9);
    idle(5);
    checkAll("R2 capture", -17);

    // R3 second start lands in the first busy cycle of every schedule
    pulseStart(10, 10, 1, 1, 1);
    pulseStart(2, 2, 2, 2, 2);
    idle(6);
    checkAll("R3 ignored", 100);

    // R5 start held high: each schedule restarts in its done cycle
    opA = 8'(3); opB = 8'(4); opC = 8'(1); opD = 8'(2); opF = 8'(0);
    start = 1'b1;
    idle(10);
    start = 1'b0;
    idle(5);
    checkAll("R5 back-to-back", 10);

    // R7 random operands, random spacing, schedules agree
    for (int i = 0; i < 200; i++) begin
      pulseStart(int'($urandom), int'($urandom), int'($urandom), int'($urandom), int'($urandom));
      idle(4 + int'($urandom_range(0, 2)));
      check(resV[0] == resV[2], "R7 one vs three", 3, int'(resV[2]), int'(resV[0]));
      check(resV[1] == resV[2], "R7 two vs three", 3, int'(resV[2]), int'(resV[1]));
    end

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

endmodule